// File: doc/BRIEF.md
# Pin Interrupt Summary and Host Line Controller

This block collects the pending-interrupt flags of a large bank of pins and folds them into a compact summary vector. Every four consecutive pins share one summary bit, so 184 pins give 46 summary bits. Software reads the summary through two 32-bit words to find which groups need attention. It then services the pins in those groups. Each pin's own detector and its clear path sit outside this block and arrive as one pending vector.

A single level output, `hostIrq`, alerts the host. When the line is armed and any summary bit is set, the line pulses high for one cycle and then stays low, whatever the pins do, until software writes the end-of-interrupt bit of the control word. If pins are still pending at that write, the line pulses again on the next cycle. Otherwise the line goes back to the armed state. The end-of-interrupt bit is a write-only strobe.

Register space is addressed by word: summary words come first (address 0 holds groups 0..31, address 1 holds groups 32..45), and the control word follows them at address 2. Read data is registered.

Top module: `pin_irq_summary`

## Requirements
- R1: Summary bit n is 1 exactly when at least one of `pinPending[4n]` .. `pinPending[4n+3]` is 1, for n = 0..45.
- R2: A read of address 0 returns summary bits 31:0. A read of address 1 returns summary bits 45:32 in data bits 13:0, and data bits 31:14 are zero.
- R3: `busRdData` takes the addressed word at the clock edge where `busRdEn` is high. It then holds that value, unchanged by pin activity, until the next read.
- R4: While armed, an edge that sees any summary bit set makes `hostIrq` high for exactly the next cycle. It is low in the cycle after that.
- R5: After a pulse, `hostIrq` stays low for as long as no end-of-interrupt write arrives, even when more pins become pending.
- R6: An end-of-interrupt write is a write to address 2 with data bit 0 = 1. If any summary bit is set at that edge, `hostIrq` is high for exactly the following cycle.
- R7: An end-of-interrupt write while no summary bit is set leaves `hostIrq` low and re-arms the line, so a later pending pin produces an R4 pulse.
- R8: A read of address 2 always returns zero, including right after an end-of-interrupt write.
- R9: Writes to addresses 0 and 1, and writes to address 2 with data bit 0 = 0, change neither the summary nor `hostIrq`.
- R10: During and right after reset, `hostIrq` is 0, `busRdData` is 0 and the line is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pinPending | input | 184 | Per-pin pending interrupt or wake flag |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | 2 | Word address: 0 low summary, 1 high summary, 2 control |
| busWrData | input | 32 | Write data; bit 0 of the control word is end-of-interrupt |
| busRdData | output | 32 | Registered read data |
| hostIrq | output | 1 | Combined interrupt line to the host |

## Verification
The summary is driven with single pins at both ends of a group (pins 0, 3, 4), at the word seam (pins 127 and 128), and at the last pin (183). These patterns show the group mapping and the split between the two words. Two pins in one group show that hits merge. An all-ones vector shows that the unused upper bits of the high word stay zero. The line is then run through three cases: a first pulse, a blocked period with added pins and ignored writes, and end-of-interrupt writes made with pins still pending and with nothing pending. These separate a re-fire from a re-arm.

// File: rtl/pin_irq_summary_pkg.sv
package pin_irq_summary_pkg;

  // width of the word-select field carried in the strobe struct
  localparam int unsigned SEL_W = 4;

  // line controller states
  typedef enum logic [1:0] {
    ST_ARMED   = 2'd0,
    ST_FIRE    = 2'd1,
    ST_BLOCKED = 2'd2
  } line_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic             rdLoad;
    logic             rdSummary;
    logic             rdControl;
    logic [SEL_W-1:0] rdWord;
  } rd_strobe_t;

endpackage

// File: rtl/pin_irq_summary_datapath.sv
module pin_irq_summary_datapath
  import pin_irq_summary_pkg::*;
#(
  parameter int unsigned NUM_PINS       = 184,
  parameter int unsigned PINS_PER_GROUP = 4,
  parameter int unsigned WORD_W         = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinPending,
  input  rd_strobe_t          strobes,
  output logic                anyPending,
  output logic [WORD_W-1:0]   busRdData
);

  localparam int unsigned NUM_GROUPS = (NUM_PINS + PINS_PER_GROUP - 1) / PINS_PER_GROUP;
  localparam int unsigned PADDED     = NUM_GROUPS * PINS_PER_GROUP;
  localparam int unsigned NUM_WORDS  = (NUM_GROUPS + WORD_W - 1) / WORD_W;
  localparam int unsigned WIDE_W     = NUM_WORDS * WORD_W;
  localparam int unsigned HIGH_USED  = NUM_GROUPS - (NUM_WORDS - 1) * WORD_W;
  localparam logic [WORD_W-1:0] HIGH_MASK =
    WORD_W'((64'(1) << HIGH_USED) - 64'(1));

  logic [PADDED-1:0]     paddedPins;
  logic [NUM_GROUPS-1:0] groupHit;
  logic [WIDE_W-1:0]     summaryWide;
  logic [WORD_W-1:0]     summaryWord [NUM_WORDS];
  logic [WORD_W-1:0]     nextRd;
  logic [WORD_W-1:0]     rdReg;

  assign paddedPins = PADDED'(pinPending);

  // one OR per group of pins
  generate
    for (genvar g = 0; g < NUM_GROUPS; g++) begin : gen_group
      assign groupHit[g] = |paddedPins[g*PINS_PER_GROUP +: PINS_PER_GROUP];
    end
  endgenerate

  assign summaryWide = WIDE_W'(groupHit);
  assign anyPending  = |groupHit;

  generate
    for (genvar w = 0; w < NUM_WORDS; w++) begin : gen_word
      assign summaryWord[w] = summaryWide[w*WORD_W +: WORD_W];
    end
  endgenerate

  // read selection; the control word has no readable state
  always_comb begin
    nextRd = '0;
    if (strobes.rdSummary) begin
      for (int w = 0; w < NUM_WORDS; w++) begin
        if (strobes.rdWord == SEL_W'(w)) nextRd = summaryWord[w];
      end
    end else if (strobes.rdControl) begin
      nextRd = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)               rdReg <= '0;
    else if (strobes.rdLoad) rdReg <= nextRd;
  end

  assign busRdData = rdReg;

  // R1: group reduction agrees with a flat OR of all pins
  a_r1_any_matches_pins: assert property (@(posedge clk) disable iff (!rstN)
    anyPending == (|pinPending))
    else $error("a_r1_any_matches_pins");

  // R2: upper bits of the last summary word read as zero
  a_r2_high_word_pad: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdLoad && strobes.rdSummary && strobes.rdWord == SEL_W'(NUM_WORDS - 1)
    |=> (busRdData & ~HIGH_MASK) == '0)
    else $error("a_r2_high_word_pad");

  // R8: control word reads back as zero
  a_r8_control_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    strobes.rdLoad && strobes.rdControl |=> busRdData == '0)
    else $error("a_r8_control_reads_zero");

  // R3: read data holds between reads
  a_r3_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.rdLoad |=> $stable(busRdData))
    else $error("a_r3_hold");

endmodule

// File: rtl/pin_irq_summary_ctrl.sv
module pin_irq_summary_ctrl
  import pin_irq_summary_pkg::*;
#(
  parameter int unsigned NUM_WORDS = 2,
  parameter int unsigned ADDR_W    = 2,
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned EOI_BIT   = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [WORD_W-1:0] busWrData,
  input  logic              anyPending,
  output rd_strobe_t        strobes,
  output logic              hostIrq
);

  localparam logic [ADDR_W-1:0] CONTROL_ADDR = ADDR_W'(NUM_WORDS);

  line_state_t state;
  line_state_t stateNext;
  logic        controlHit;
  logic        summaryHit;
  logic        eoiStrobe;
  logic        unusedWrBits;

  assign controlHit   = (busAddr == CONTROL_ADDR);
  assign summaryHit   = (busAddr < CONTROL_ADDR);
  assign eoiStrobe    = busWrEn && controlHit && busWrData[EOI_BIT];
  assign unusedWrBits = ^busWrData;

  always_comb begin
    strobes.rdLoad    = busRdEn;
    strobes.rdSummary = summaryHit;
    strobes.rdControl = controlHit;
    strobes.rdWord    = SEL_W'(busAddr);
  end

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_ARMED:   if (anyPending) stateNext = ST_FIRE;
      ST_FIRE:    stateNext = ST_BLOCKED;
      ST_BLOCKED: if (eoiStrobe) stateNext = anyPending ? ST_FIRE : ST_ARMED;
      default:    stateNext = ST_ARMED;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_ARMED;
    else       state <= stateNext;
  end

  assign hostIrq = (state == ST_FIRE);

  // R4: armed line fires on the first pending edge
  a_r4_fire_when_armed: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_ARMED && anyPending |=> hostIrq)
    else $error("a_r4_fire_when_armed");

  // R4: the pulse lasts one cycle
  a_r4_single_cycle: assert property (@(posedge clk) disable iff (!rstN)
    hostIrq |=> !hostIrq)
    else $error("a_r4_single_cycle");

  // R5: blocked line stays low without an EOI
  a_r5_blocked_low: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BLOCKED && !eoiStrobe |=> !hostIrq)
    else $error("a_r5_blocked_low");

  // R6: EOI with work left fires again
  a_r6_eoi_refire: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BLOCKED && eoiStrobe && anyPending |=> hostIrq)
    else $error("a_r6_eoi_refire");

  // R7: EOI with nothing pending re-arms quietly
  a_r7_eoi_rearm: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_BLOCKED && eoiStrobe && !anyPending |=> !hostIrq && state == ST_ARMED)
    else $error("a_r7_eoi_rearm");

endmodule

// File: rtl/pin_irq_summary.sv
module pin_irq_summary
  import pin_irq_summary_pkg::*;
#(
  parameter int unsigned NUM_PINS       = 184,
  parameter int unsigned PINS_PER_GROUP = 4,
  parameter int unsigned WORD_W         = 32,
  parameter int unsigned ADDR_W         = 2,
  parameter int unsigned EOI_BIT        = 0
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [NUM_PINS-1:0] pinPending,
  input  logic                busWrEn,
  input  logic                busRdEn,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [WORD_W-1:0]   busWrData,
  output logic [WORD_W-1:0]   busRdData,
  output logic                hostIrq
);

  localparam int unsigned NUM_GROUPS = (NUM_PINS + PINS_PER_GROUP - 1) / PINS_PER_GROUP;
  localparam int unsigned NUM_WORDS  = (NUM_GROUPS + WORD_W - 1) / WORD_W;

  rd_strobe_t strobes;
  logic       anyPending;

  pin_irq_summary_ctrl #(
    .NUM_WORDS (NUM_WORDS),
    .ADDR_W    (ADDR_W),
    .WORD_W    (WORD_W),
    .EOI_BIT   (EOI_BIT)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .anyPending (anyPending),
    .strobes    (strobes),
    .hostIrq    (hostIrq)
  );

  pin_irq_summary_datapath #(
    .NUM_PINS       (NUM_PINS),
    .PINS_PER_GROUP (PINS_PER_GROUP),
    .WORD_W         (WORD_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .pinPending (pinPending),
    .strobes    (strobes),
    .anyPending (anyPending),
    .busRdData  (busRdData)
  );

endmodule

// File: tb/pin_irq_summary_bench.sv
module pin_irq_summary_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NPINS      = 184;

  typedef struct packed {
    int          pinA;
    int          pinB;
    logic        allOnes;
    logic [31:0] expLow;
    logic [31:0] expHigh;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{-1,  -1, 1'b0, 32'h0000_0000, 32'h0000_0000},
    '{ 0,  -1, 1'b0, 32'h0000_0001, 32'h0000_0000},
    '{ 3,  -1, 1'b0, 32'h0000_0001, 32'h0000_0000},
    '{ 4,  -1, 1'b0, 32'h0000_0002, 32'h0000_0000},
    '{ 1,   2, 1'b0, 32'h0000_0001, 32'h0000_0000},
    '{127, -1, 1'b0, 32'h8000_0000, 32'h0000_0000},
    '{128, -1, 1'b0, 32'h0000_0000, 32'h0000_0001},
    '{183, 20, 1'b0, 32'h0000_0020, 32'h0000_2000},
    '{-1,  -1, 1'b1, 32'hFFFF_FFFF, 32'h0000_3FFF}
  };

  logic             clk = 1'b0;
  logic             rstN;
  logic [NPINS-1:0] pins;
  logic             busWrEn;
  logic             busRdEn;
  logic [1:0]       busAddr;
  logic [31:0]      busWrData;
  logic [31:0]      busRdData;
  logic             hostIrq;
  int               total = 0;
  int               bad = 0;
  logic [31:0]      rd;

  always #(CLK_PERIOD/2) clk = ~clk;

  pin_irq_summary u_pin_irq_summary (
    .clk        (clk),
    .rstN       (rstN),
    .pinPending (pins),
    .busWrEn    (busWrEn),
    .busRdEn    (busRdEn),
    .busAddr    (busAddr),
    .busWrData  (busWrData),
    .busRdData  (busRdData),
    .hostIrq    (hostIrq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic busRead(input logic [1:0] addr, output logic [31:0] data);
    busRdEn = 1'b1;
    busAddr = addr;
    @(posedge clk);
    @(negedge clk);
    busRdEn = 1'b0;
    data = busRdData;
  endtask

  task automatic busWrite(input logic [1:0] addr, input logic [31:0] data);
    busWrEn   = 1'b1;
    busAddr   = addr;
    busWrData = data;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic applyReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    pins = '0; busWrEn = 1'b0; busRdEn = 1'b0; busAddr = '0; busWrData = '0;
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 reset hostIrq", 32'(hostIrq), 32'd0);
    check("R10 reset busRdData", busRdData, 32'd0);
    rstN = 1'b1;

    // table walk over pin patterns
    for (int i = 0; i < NVEC; i++) begin
      pins = VECS[i].allOnes ? '1 : '0;
      if (VECS[i].pinA >= 0) pins[VECS[i].pinA] = 1'b1;
      if (VECS[i].pinB >= 0) pins[VECS[i].pinB] = 1'b1;
      busRead(2'd0, rd);
      check($sformatf("R1 low word vec %0d", i), rd, VECS[i].expLow);
      busRead(2'd1, rd);
      check($sformatf("R2 high word vec %0d", i), rd, VECS[i].expHigh);
    end

    // R3: read data held while pins change
    pins = '0;
    repeat (3) @(negedge clk);
    check("R3 hold after pins drop", busRdData, 32'h0000_3FFF);
    busRead(2'd0, rd);
    check("R3 new read", rd, 32'd0);

    applyReset();
    check("R10 armed and low after reset", 32'(hostIrq), 32'd0);

    // R4: first pulse
    pins[10] = 1'b1;
    @(negedge clk);
    check("R4 pulse high", 32'(hostIrq), 32'd1);
    @(negedge clk);
    check("R4 pulse ends", 32'(hostIrq), 32'd0);

    // R5: blocked while more pins arrive
    pins[100] = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R5 blocked low", 32'(hostIrq), 32'd0);
    end

    // R9: ignored writes
    busWrite(2'd0, 32'hFFFF_FFFF);
    busWrite(2'd1, 32'hFFFF_FFFF);
    busWrite(2'd2, 32'hFFFF_FFFE);
    check("R9 no pulse from ignored writes", 32'(hostIrq), 32'd0);
    busRead(2'd0, rd);
    check("R9 low summary intact", rd, 32'h0200_0004);
    busRead(2'd1, rd);
    check("R9 high summary intact", rd, 32'd0);
    check("R9 still blocked", 32'(hostIrq), 32'd0);

    busRead(2'd2, rd);
    check("R8 control reads zero", rd, 32'd0);

    // R6: EOI with pins still pending
    busWrite(2'd2, 32'h0000_0001);
    check("R6 refire after EOI", 32'(hostIrq), 32'd1);
    @(negedge clk);
    check("R6 refire one cycle", 32'(hostIrq), 32'd0);
    busRead(2'd2, rd);
    check("R8 EOI self clears", rd, 32'd0);

    // R7: EOI with nothing pending re-arms
    pins = '0;
    @(negedge clk);
    busWrite(2'd2, 32'h0000_0001);
    check("R7 no pulse on empty EOI", 32'(hostIrq), 32'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check("R7 quiet while armed", 32'(hostIrq), 32'd0);
    end
    pins[183] = 1'b1;
    @(negedge clk);
    check("R7 rearmed line fires", 32'(hostIrq), 32'd1);
    @(negedge clk);
    check("R7 pulse ends", 32'(hostIrq), 32'd0);
    busRead(2'd1, rd);
    check("R2 last pin in high word", rd, 32'h0000_2000);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule